// File: doc/BRIEF.md
# Single-Source Non-Maskable Interrupt Controller

This block watches one asynchronous interrupt pin and turns a chosen kind of activity on that pin into a request for a parent interrupt controller. Software picks one of four trigger kinds (active-low level, falling edge, active-high level, rising edge) through a 2-bit mode field. When the pin shows the chosen activity, a sticky pending flag is set. Software clears it by writing a one to it. The request output is raised only while the flag is pending and the enable bit is set.

Software reaches the block over a plain 32-bit register port with an address, a write strobe, write data and combinational read data. The pin passes through a two-stage synchronizer before detection. A build-time parameter places the enable register at one of two offsets. The usual handler sequence works without losing events: disable, acknowledge, re-enable. Because the request depends only on pending and enable, a handler that reads pending as zero can tell that the request was spurious.

Top module: `nmi_irq_ctrl`

## Requirements
- R1: After reset the mode field is 0, pending is 0, enable is 0 and `irqOut` is low.
- R2: The mode register is at offset 0x0. Bits [1:0] hold the mode, coded as 0 low level, 1 falling edge, 2 high level and 3 rising edge. Its other bits read as zero.
- R3: In mode 0, pending is set on every cycle the synchronized pin is low. An acknowledge has no lasting effect while the pin stays low.
- R4: In mode 1, each high-to-low transition of the synchronized pin sets pending once. An acknowledge while the pin stays low leaves pending clear.
- R5: In mode 2, pending is set on every cycle the synchronized pin is high. An acknowledge has no lasting effect while the pin stays high.
- R6: In mode 3, each low-to-high transition of the synchronized pin sets pending once. A high-to-low transition does not set it.
- R7: The pending flag is bit 0 at offset 0x4. Writing 1 to that bit clears it. Writing 0 leaves it unchanged. Pending changes only through an event or an acknowledge.
- R8: The enable bit is bit 0 of the register at offset 0x8 (or at 0x34 when `ALT_ENABLE_OFS` is 1). `irqOut` is pending AND enable. Events are recorded while enable is 0.
- R9: When an event and an acknowledge fall on the same cycle, pending ends set.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no state.
- R11: A change on the pin appears in pending on the third rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWe | input | 1 | Write strobe |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| nmiIn | input | 1 | Asynchronous interrupt pin |
| irqOut | output | 1 | Request to the parent controller |

## Verification
The hardest situation to reach is an acknowledge landing on the same clock edge as a freshly detected edge event. The pin delay is fixed at three edges, so the bench counts edges from a pin change and issues the acknowledge write in the exact cycle the event is detected. The other difficult case is an acknowledge during an active level. For that, the table drives the starting level, acknowledges while that level is still held, then moves the pin, so each row shows whether the flag came back from the held level or from the transition.

// File: rtl/nmi_irq_pkg.sv
package nmi_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_HIGH_LVL = 2'd2,
    TRIG_RISE     = 2'd3
  } trigMode_t;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_MODE,
    RSEL_PEND,
    RSEL_EN
  } rdSel_t;

  typedef struct packed {
    logic   wrMode;
    logic   wrEnable;
    logic   ackPend;
    rdSel_t rdSel;
  } ctrlStrobe_t;

  localparam int unsigned MODE_OFS  = 'h0;
  localparam int unsigned PEND_OFS  = 'h4;
  localparam int unsigned EN_OFS_A  = 'h8;
  localparam int unsigned EN_OFS_B  = 'h34;

endpackage

// File: rtl/nmi_irq_decode.sv
module nmi_irq_decode
  import nmi_irq_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter bit ALT_ENABLE_OFS = 1'b0
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              wrBit0,
  output ctrlStrobe_t       strobe
);

  localparam int unsigned EN_OFS = ALT_ENABLE_OFS ? EN_OFS_B : EN_OFS_A;

  logic hitMode;
  logic hitPend;
  logic hitEn;

  assign hitMode = (regAddr == ADDR_W'(MODE_OFS));
  assign hitPend = (regAddr == ADDR_W'(PEND_OFS));
  assign hitEn   = (regAddr == ADDR_W'(EN_OFS));

  always_comb begin
    strobe          = '0;
    strobe.wrMode   = regWe && hitMode;
    strobe.wrEnable = regWe && hitEn;
    strobe.ackPend  = regWe && hitPend && wrBit0;
    if (hitMode)      strobe.rdSel = RSEL_MODE;
    else if (hitPend) strobe.rdSel = RSEL_PEND;
    else if (hitEn)   strobe.rdSel = RSEL_EN;
    else              strobe.rdSel = RSEL_NONE;
  end

endmodule

// File: rtl/nmi_irq_core.sv
module nmi_irq_core
  import nmi_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiIn,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        wrLow,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output trigMode_t         modeQ,
  output logic              pendQ,
  output logic              enQ,
  output logic              evtHit
);

  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int PRIME_W   = $clog2(PRIME_MAX + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncNow;
  logic                   syncPrev;
  logic [PRIME_W-1:0]     primeCnt;
  logic                   primed;
  logic                   rawHit;

  // synchronizer stages
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= nmiIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign syncNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncNow;
  end

  // detection stays off until every stage holds a real sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          primeCnt <= '0;
    else if (primeCnt != PRIME_W'(PRIME_MAX)) primeCnt <= primeCnt + 1'b1;
  end

  assign primed = (primeCnt == PRIME_W'(PRIME_MAX));

  always_comb begin
    unique case (modeQ)
      TRIG_LOW_LVL:  rawHit = !syncNow;
      TRIG_FALL:     rawHit = syncPrev && !syncNow;
      TRIG_HIGH_LVL: rawHit = syncNow;
      TRIG_RISE:     rawHit = !syncPrev && syncNow;
      default:       rawHit = 1'b0;
    endcase
  end

  assign evtHit = primed && rawHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= TRIG_LOW_LVL;
      enQ   <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (strobe.wrMode)   modeQ <= trigMode_t'(wrLow);
      if (strobe.wrEnable) enQ   <= wrLow[0];
      if (evtHit)              pendQ <= 1'b1;
      else if (strobe.ackPend) pendQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RSEL_MODE: rdData[1:0] = modeQ;
      RSEL_PEND: rdData[0]   = pendQ;
      RSEL_EN:   rdData[0]   = enQ;
      default:   rdData      = '0;
    endcase
  end

  assign irqOut = pendQ && enQ;

endmodule

// File: rtl/nmi_irq_ctrl.sv
module nmi_irq_ctrl
  import nmi_irq_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 32,
  parameter int SYNC_STAGES    = 2,
  parameter bit ALT_ENABLE_OFS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              nmiIn,
  output logic              irqOut
);

  ctrlStrobe_t strobe;
  trigMode_t   modeQ;
  logic        pendQ;
  logic        enQ;
  logic        evtHit;

  nmi_irq_decode #(
    .ADDR_W        (ADDR_W),
    .ALT_ENABLE_OFS(ALT_ENABLE_OFS)
  ) decode_i (
    .regAddr(regAddr),
    .regWe  (regWe),
    .wrBit0 (regWdata[0]),
    .strobe (strobe)
  );

  nmi_irq_core #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) core_i (
    .clk   (clk),
    .rstN  (rstN),
    .nmiIn (nmiIn),
    .strobe(strobe),
    .wrLow (regWdata[1:0]),
    .rdData(regRdata),
    .irqOut(irqOut),
    .modeQ (modeQ),
    .pendQ (pendQ),
    .enQ   (enQ),
    .evtHit(evtHit)
  );

endmodule

// File: rtl/nmi_irq_chk.sv
module nmi_irq_chk
  import nmi_irq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input ctrlStrobe_t strobe,
  input trigMode_t   modeQ,
  input logic        pendQ,
  input logic        enQ,
  input logic        evtHit,
  input logic        irqOut
);

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!pendQ && !enQ && !irqOut && modeQ == TRIG_LOW_LVL);
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |=> pendQ);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackPend && !evtHit) |=> !pendQ);

  // R7
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(evtHit));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evtHit && !strobe.ackPend) |=> $stable(pendQ));

  // R8
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> enQ);

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == TRIG_FALL || modeQ == TRIG_RISE) && evtHit && !strobe.wrMode) |=> !evtHit);

endmodule

bind nmi_irq_ctrl nmi_irq_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .strobe(strobe),
  .modeQ (modeQ),
  .pendQ (pendQ),
  .enQ   (enQ),
  .evtHit(evtHit),
  .irqOut(irqOut)
);

// File: tb/nmi_irq_ctrl_tb.sv
module nmi_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        nmiIn = 1'b1;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nmi_irq_ctrl dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .nmiIn   (nmiIn),
    .irqOut  (irqOut)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       inA;
    logic       inB;
    logic       en;
    logic       expPend;
  } vec_t;

  // mode, start level, end level, enable, expected pending
  localparam vec_t VECS [12] = '{
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr  = a;
    regWdata = d;
    regWe    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    settle(2);
    // R1 reset state
    rdReg(8'h00, rd); check("R1 mode", rd, 32'h0);
    rdReg(8'h04, rd); check("R1 pending", rd, 32'h0);
    rdReg(8'h08, rd); check("R1 enable", rd, 32'h0);
    check("R1 irqOut", {31'd0, irqOut}, 32'h0);
    rstN = 1'b1;
    settle(6);

    // R2 mode field width and readback
    wrReg(8'h00, 32'hFFFF_FFFE);
    rdReg(8'h00, rd); check("R2 mode readback", rd, 32'h2);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      nmiIn = VECS[i].inA;
      wrReg(8'h00, {30'd0, VECS[i].mode});
      wrReg(8'h08, {31'd0, VECS[i].en});
      settle(5);
      wrReg(8'h04, 32'h1);
      nmiIn = VECS[i].inB;
      settle(5);
      rdReg(8'h04, rd);
      check($sformatf("R3/R4/R5/R6 vec %0d pending", i), rd, {31'd0, VECS[i].expPend});
      check($sformatf("R8 vec %0d irqOut", i), {31'd0, irqOut},
            {31'd0, VECS[i].expPend & VECS[i].en});
    end

    // R7 writing zero does not clear, writing one does
    nmiIn = 1'b1;
    wrReg(8'h00, 32'h2);
    settle(5);
    wrReg(8'h00, 32'h3);
    nmiIn = 1'b0;
    settle(5);
    rdReg(8'h04, rd); check("R7 pending before ack", rd, 32'h1);
    wrReg(8'h04, 32'h0);
    rdReg(8'h04, rd); check("R7 write zero keeps pending", rd, 32'h1);
    wrReg(8'h04, 32'h1);
    rdReg(8'h04, rd); check("R7 write one clears", rd, 32'h0);

    // R8 enable readback
    wrReg(8'h08, 32'hFFFF_FFFF);
    rdReg(8'h08, rd); check("R8 enable readback", rd, 32'h1);

    // R10 unmapped offsets
    wrReg(8'h10, 32'hFFFF_FFFF);
    wrReg(8'h34, 32'h0);
    rdReg(8'h10, rd); check("R10 unmapped read", rd, 32'h0);
    rdReg(8'h34, rd); check("R10 alternate enable offset unmapped", rd, 32'h0);
    rdReg(8'h00, rd); check("R10 mode unchanged", rd, 32'h3);
    rdReg(8'h08, rd); check("R10 enable unchanged", rd, 32'h1);

    // R11 latency in high-level mode
    nmiIn = 1'b0;
    wrReg(8'h00, 32'h2);
    settle(5);
    wrReg(8'h04, 32'h1);
    nmiIn = 1'b1;
    settle(2);
    rdReg(8'h04, rd); check("R11 not yet after two edges", rd, 32'h0);
    settle(1);
    rdReg(8'h04, rd); check("R11 set on third edge", rd, 32'h1);

    // R9 event and acknowledge on the same edge (rising mode)
    nmiIn = 1'b0;
    wrReg(8'h00, 32'h3);
    settle(5);
    wrReg(8'h04, 32'h1);
    rdReg(8'h04, rd); check("R9 cleared before edge", rd, 32'h0);
    nmiIn = 1'b1;
    settle(2);
    wrReg(8'h04, 32'h1);
    rdReg(8'h04, rd); check("R9 set wins over ack", rd, 32'h1);

    // R4 single event per falling edge while held low
    nmiIn = 1'b1;
    wrReg(8'h00, 32'h1);
    settle(5);
    wrReg(8'h04, 32'h1);
    nmiIn = 1'b0;
    settle(5);
    rdReg(8'h04, rd); check("R4 falling edge sets", rd, 32'h1);
    wrReg(8'h04, 32'h1);
    settle(5);
    rdReg(8'h04, rd); check("R4 held low stays clear", rd, 32'h0);
    check("R8 irqOut low after ack", {31'd0, irqOut}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule